// File: doc/BRIEF.md
# Byte-Lane Carryless Multiplier, 64 x 64 to 128

This block forms the 128-bit carryless product of two 64-bit operands, the product of two polynomials with coefficients in GF(2). Partial products are added with XOR and never carry. It holds one array of eight 8x8 carryless lane multipliers, and it reuses that array over eight passes. Each pass feeds the array a byte-rotated copy of one operand and the unrotated other operand. The bytes that wrap around are folded back into the right lanes. The folded vector is then shifted into place and XORed into an accumulator.

A caller raises `start` for one cycle with the operands on `a` and `b`. After a fixed number of cycles the block pulses `done` and presents the product on `p`. The controller is a state machine with three states:
- `S_IDLE` waits for `start`. The transition *launch* (start seen) captures the operands and clears the accumulator.
- `S_PASS` runs the eight lane-array passes, one per cycle. The transition *passes_done* (the last pass) moves to the next state.
- `S_FINISH` is the recombination cycle. It registers the product, raises `done`, and takes the transition *retire* back to `S_IDLE`.

Top module: `clmul64_lanes`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0 and `p` is all zeros.
- R2: The product is correct. Bit k of `p` equals the XOR, over all i+j=k, of a[i]&b[j]. Bit 0 of each operand is the constant coefficient, and byte 0 is bits 7:0.
- R3: The latency is fixed. If `start` is high at rising edge n while the block is idle, then `done` is high in the cycle that follows edge n+9. The latency does not depend on the operand values.
- R4: `done` stays high for exactly one cycle. `p` keeps its value until the next `done` pulse.
- R5: While an operation is in progress, `start` is ignored. The result is not changed, and no extra `done` pulse appears.
- R6: If either operand is zero, the product is zero.
- R7: Products whose partial terms come from the wrap-around lanes are exact. These include all-ones operands, top-byte operands and single-bit operands up to bit 63, so bit 126 of `p` can be reached.
- R8: A `start` given in the same cycle that `done` is high is accepted. Its result follows 9 edges later, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled only when idle |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| done | output | 1 | One-cycle result-valid pulse |
| p | output | 128 | Carryless product, held between pulses |

## Verification
The case hardest to reach from the ports is the wrap-around lane terms. Here a byte product lands in the upper half of a lane vector and must be folded into the lower half before the shift. Only certain byte pairs reach it, and random data hides a mistake among many other terms. The stimulus therefore sweeps single-bit operands across byte boundaries up to bit 63, and adds all-ones and top-byte operands. Each result is compared against a bit-serial shift-and-XOR model.

Two timing cases are also driven from the ports:
- A second `start` is pulsed in the middle of an operation, to check that it is ignored.
- A new `start` is raised in the very cycle that `done` is high, to check that it is accepted.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PASS   = 2'd1,
        S_FINISH = 2'd2
    } clmul_state_e;

endpackage

// File: rtl/clmul_byte_rotator.sv
module clmul_byte_rotator #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int OP_W  = LANE_W * LANES,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [OP_W-1:0]  x,
    input  logic [SEL_W-1:0] rot,
    output logic [OP_W-1:0]  y
);

    logic [2*OP_W-1:0] doubled;
    logic [2*OP_W-1:0] moved;

    always_comb begin
        doubled = {x, x};
        moved   = doubled >> (int'(rot) * LANE_W);
        y       = moved[OP_W-1:0];
    end

endmodule

// File: rtl/clmul_lane_array.sv
module clmul_lane_array #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int OP_W  = LANE_W * LANES,
    localparam int PR_W  = 2 * LANE_W
) (
    input  logic [OP_W-1:0]        x,
    input  logic [OP_W-1:0]        y,
    output logic [LANES*PR_W-1:0]  v
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] xb;
        logic [LANE_W-1:0] yb;
        logic [PR_W-1:0]   prod;

        assign xb = x[g*LANE_W +: LANE_W];
        assign yb = y[g*LANE_W +: LANE_W];

        always_comb begin
            prod = '0;
            for (int i = 0; i < LANE_W; i++) begin
                if (yb[i]) begin
                    prod = prod ^ (PR_W'(xb) << i);
                end
            end
            // R2: an 8x8 carryless product never reaches the lane's top bit
            lane_msb_chk: assert (prod[PR_W-1] == 1'b0);
        end

        assign v[g*PR_W +: PR_W] = prod;
    end

endmodule

// File: rtl/clmul_fold_shift.sv
module clmul_fold_shift #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int OP_W  = LANE_W * LANES,
    localparam int PR_W  = 2 * LANE_W,
    localparam int HALF  = LANES / 2,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [2*OP_W-1:0] v,
    input  logic [SEL_W-1:0]  keep,
    input  logic [SEL_W-1:0]  shift,
    output logic [2*OP_W-1:0] w
);

    logic [OP_W-1:0]   mask;
    logic [OP_W-1:0]   upper;
    logic [OP_W-1:0]   lower;
    logic [OP_W-1:0]   mixed;
    logic [OP_W-1:0]   kept;
    logic [OP_W-1:0]   restored;
    logic [2*OP_W-1:0] folded;

    for (genvar j = 0; j < HALF; j++) begin : g_mask
        assign mask[j*PR_W +: PR_W] = (keep > SEL_W'(j)) ? {PR_W{1'b1}} : {PR_W{1'b0}};
    end

    always_comb begin
        upper    = v[2*OP_W-1:OP_W];
        lower    = v[OP_W-1:0];
        mixed    = lower ^ upper;
        kept     = upper & mask;
        restored = mixed ^ kept;
        folded   = {kept, restored};
        w        = folded << (int'(shift) * LANE_W);
    end

endmodule

// File: rtl/clmul64_lanes.sv
module clmul64_lanes
    import clmul_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int OP_W  = LANE_W * LANES,
    localparam int SEL_W = $clog2(LANES),
    localparam int HALF  = LANES / 2,
    localparam logic [SEL_W-1:0] LAST = SEL_W'(LANES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic              done,
    output logic [2*OP_W-1:0] p
);

    clmul_state_e state, state_nx;

    logic [OP_W-1:0]   op_a;
    logic [OP_W-1:0]   op_b;
    logic [SEL_W-1:0]  cnt;
    logic [2*OP_W-1:0] acc;

    logic [SEL_W:0]    cnt_p1;
    logic [SEL_W-1:0]  rot_a;
    logic [SEL_W-1:0]  rot_b;
    logic [SEL_W-1:0]  shift;
    logic [SEL_W-1:0]  keep;
    logic [OP_W-1:0]   lane_x;
    logic [OP_W-1:0]   lane_y;
    logic [2*OP_W-1:0] lane_v;
    logic [2*OP_W-1:0] contrib;

    // Pass schedule: pass 0 is unrotated, odd passes rotate B, even passes rotate A
    always_comb begin
        cnt_p1 = {1'b0, cnt} + 1'b1;
        shift  = cnt_p1[SEL_W:1];
        keep   = SEL_W'(HALF) - shift;
        rot_b  = cnt[0] ? shift : '0;
        rot_a  = (!cnt[0] && cnt != '0) ? {1'b0, cnt[SEL_W-1:1]} : '0;
    end

    clmul_byte_rotator #(.LANE_W(LANE_W), .LANES(LANES)) u_rot_a (
        .x(op_a), .rot(rot_a), .y(lane_x)
    );

    clmul_byte_rotator #(.LANE_W(LANE_W), .LANES(LANES)) u_rot_b (
        .x(op_b), .rot(rot_b), .y(lane_y)
    );

    clmul_lane_array #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
        .x(lane_x), .y(lane_y), .v(lane_v)
    );

    clmul_fold_shift #(.LANE_W(LANE_W), .LANES(LANES)) u_fold (
        .v(lane_v), .keep(keep), .shift(shift), .w(contrib)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: launch, passes_done, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_PASS;
            S_PASS:   if (cnt == LAST) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
            cnt  <= '0;
            acc  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        op_a <= a;
                        op_b <= b;
                        cnt  <= '0;
                        acc  <= '0;
                    end
                end
                S_PASS: begin
                    acc <= acc ^ contrib;
                    cnt <= cnt + 1'b1;
                end
                S_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            p    <= '0;
        end else begin
            done <= (state == S_FINISH);
            if (state == S_FINISH) begin
                p <= acc;
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(op_a) && $stable(op_b)));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (state == S_PASS && cnt == '0));

    // R3
    pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS && cnt != LAST) |=> (state == S_PASS && cnt == $past(cnt) + 1'b1));

    // R3
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FINISH) |=> (done && state == S_IDLE));

endmodule

// File: tb/clmul64_lanes_bench.sv
module clmul64_lanes_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic [63:0]  xa;
        logic [63:0]  xb;
        logic [127:0] prod;
        int           due;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  a = '0;
    logic [63:0]  b = '0;
    logic         done;
    logic [127:0] p;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;
    item_t q[$];

    clmul64_lanes u_clmul64_lanes (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a), .b(b), .done(done), .p(p)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [127:0] ref_clmul(input logic [63:0] x, input logic [63:0] y);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (y[i]) r = r ^ ({64'b0, x} << i);
        end
        return r;
    endfunction

    task automatic report_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Driver: called at a negative edge, leaves at the next negative edge
    task automatic drive_op(input logic [63:0] x, input logic [63:0] y);
        item_t it;
        it.xa = x;
        it.xb = y;
        it.prod = ref_clmul(x, y);
        it.due = cyc + 10;
        q.push_back(it);
        start = 1'b1;
        a = x;
        b = y;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_op(input logic [63:0] x, input logic [63:0] y);
        drive_op(x, y);
        wait_done();
        @(negedge clk);
    endtask

    // Monitor: scoreboard compare, sampled on falling edges
    logic         prev_done = 1'b0;
    logic [127:0] prev_p = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (q.size() == 0) begin
                    mismatched++;
                    $display("FAIL R5: unexpected done, p=%h expected no result", p);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    compared++;
                    if (p !== it.prod) begin
                        mismatched++;
                        $display("FAIL R2: a=%h b=%h p=%h expected %h", it.xa, it.xb, p, it.prod);
                    end
                    compared++;
                    if (cyc != it.due) begin
                        mismatched++;
                        $display("FAIL R3: done at cycle %0d expected %0d", cyc, it.due);
                    end
                end
                if (prev_done) begin
                    mismatched++;
                    $display("FAIL R4: done high %0d cycles expected 1", 2);
                end
            end else if (p !== prev_p) begin
                mismatched++;
                $display("FAIL R4: p changed without done, p=%h expected %h", p, prev_p);
            end
            prev_done = done;
            prev_p = p;
        end
    end

    always @(posedge clk) begin
        if (cyc >= WATCHDOG && !finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog: cycle %0d expected under %0d", cyc, WATCHDOG);
            report_summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear during reset
        compared++;
        if (done !== 1'b0 || p !== '0) begin
            mismatched++;
            $display("FAIL R1: done=%b p=%h expected 0 and 0", done, p);
        end
        rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (done !== 1'b0 || p !== '0) begin
            mismatched++;
            $display("FAIL R1: after reset done=%b p=%h expected 0 and 0", done, p);
        end

        // R6: zero operands
        run_op(64'h0, 64'h0);
        run_op(64'h0, {$urandom, $urandom});
        run_op({$urandom, $urandom}, 64'h0);

        // R7: wrap-around lanes
        run_op('1, '1);
        run_op(64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0000);
        run_op(64'h0000_0000_0000_00FF, 64'hFF00_0000_0000_0000);
        run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        for (int i = 0; i < 64; i += 7) begin
            for (int j = 3; j < 64; j += 11) begin
                run_op(64'h1 << i, 64'h1 << j);
            end
        end

        // R2: random operands
        for (int k = 0; k < 100; k++) begin
            run_op({$urandom, $urandom}, {$urandom, $urandom});
        end

        // R5: start during a pass is ignored
        drive_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        repeat (3) @(negedge clk);
        start = 1'b1;
        a = '1;
        b = '1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (15) @(negedge clk);

        // R8: back-to-back launches on the done cycle
        drive_op({$urandom, $urandom}, {$urandom, $urandom});
        for (int k = 0; k < 6; k++) begin
            wait_done();
            drive_op({$urandom, $urandom}, {$urandom, $urandom});
        end
        wait_done();
        repeat (15) @(negedge clk);

        compared++;
        if (q.size() != 0) begin
            mismatched++;
            $display("FAIL R3: %0d results missing expected 0", q.size());
        end
        finished = 1'b1;
        report_summary();
    end

endmodule